// File: doc/BRIEF.md
# Processor-Array Recovery Sequencer

This block sits beside the control unit of a SIMD processor array and decides how to recover when something goes wrong. Each processor can report a bad result or a finished pixel. Either report queues a self-check of that processor's constant data. The sequencer runs these self-checks one processor at a time.

When a self-check fails, the sequencer resets that processor, has its constants reloaded from a protected copy, and repeats the check. If several processors are flagged at once, it first resets the shared operation block and runs a test sequence through it. When the local steps do not fix the fault, it raises a sticky request for a full-device reconfiguration. A status word reports OK or reprogram-needed, together with the unit that failed.

A watchdog input overrides everything. It halts the sequencer and requests reconfiguration on the next clock edge.

Top module: `rps_recovery_seq`

## Requirements
- R1: After reset, `status_o` is all zeros and every flag and control output is 0.
- R2: A pulse on `err_mark_i[p]` sets `err_flag_o[p]` from the next clock edge. The flag stays set until a self-check of processor p passes.
- R3: A pulse on `pixel_done_i[p]` or `err_mark_i[p]` queues a self-check of p.
  - Queued checks are started one at a time, lowest index first.
  - Each start is a single-cycle one-hot pulse on `chk_start_o`.
  - The result is taken from `chk_done_i`, with `chk_fail_i` high meaning fail.
- R4: On the first failed check of p, the sequencer does the following in order:
  - pulses `proc_rst_o[p]` for one cycle;
  - on the next cycle, pulses `reload_o[p]` for one cycle;
  - waits for `reload_done_i`;
  - starts the check of p again.
- R5: A second consecutive failed check of p sets reprogram-needed, with location code 3 and index p.
- R6: When the number of set error flags reaches `MULTI_MIN` (default 2), the shared-block test runs before any queued check.
  - The test runs once while the count stays at or above the threshold.
  - It pulses `sob_rst_o` for one cycle, then pulses `sob_start_o` on the next cycle, then waits for `sob_done_i`.
  - With a single flag set, the test never runs.
- R7: A shared-block test that ends with `sob_fail_i` high sets reprogram-needed with location code 2.
- R8: `wdog_i` high at a clock edge in any state sets reprogram-needed with location code 1 at that edge.
- R9: Once reprogram-needed is set, `status_o` holds its value until reset. While it is set, no check, reset, reload or shared-block pulse is issued.
- R10: The fields of `status_o` are:
  - bit 0: 1 means reprogram-needed, 0 means OK.
  - bits [2:1]: location code. 0 is none, 1 is control unit, 2 is shared block, 3 is processor.
  - bits [3 +: IDX_W]: index of the failing processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_mark_i | input | N_PROC | Pulse per processor: result marked bad |
| pixel_done_i | input | N_PROC | Pulse per processor: pixel finished |
| wdog_i | input | 1 | Watchdog expiry |
| chk_done_i | input | 1 | Self-check of the selected processor finished |
| chk_fail_i | input | 1 | Self-check result, valid with chk_done_i |
| reload_done_i | input | 1 | Constant reload finished |
| sob_done_i | input | 1 | Shared-block test finished |
| sob_fail_i | input | 1 | Shared-block test result, valid with sob_done_i |
| err_flag_o | output | N_PROC | Sticky error flag per processor |
| chk_start_o | output | N_PROC | One-hot self-check start pulse |
| proc_rst_o | output | N_PROC | One-hot processor reset pulse |
| reload_o | output | N_PROC | One-hot constant reload start pulse |
| sob_rst_o | output | 1 | Shared-block reset pulse |
| sob_start_o | output | 1 | Shared-block test start pulse |
| status_o | output | 3+IDX_W | Status word, layout per R10 |

## Verification
The hardest situation to reach is a processor that fails twice in a row, because it needs a full check, reset, reload and re-check round trip. Shared-block ordering is similarly hard: it needs several flags set in the same window so that the shared test must come before any queued check.

A responder process in the bench answers every check, reload and shared-test request one cycle after it sees the start pulse. It fails a check only as many times as the stimulus has allowed for that processor. This lets directed cases schedule exactly one failure, two failures, or a failing shared test. Random rounds then mix pixel and error pulses with single failures, and predict the pulse counts per processor.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK_GO, S_CHK_WAIT, S_PRST, S_LOAD_GO,
    S_LOAD_WAIT, S_SH_RST, S_SH_GO, S_SH_WAIT, S_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    LOC_NONE   = 2'd0,
    LOC_CTRL   = 2'd1,
    LOC_SHARED = 2'd2,
    LOC_PROC   = 2'd3
  } fault_loc_e;

  // number of set bits in a flag vector
  function automatic int unsigned flag_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

  // index of the lowest set bit (0 when none)
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/rps_flag_bank.sv
module rps_flag_bank #(
  parameter int N_PROC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] mark_i,
  input  logic [N_PROC-1:0] pixel_i,
  input  logic [N_PROC-1:0] clear_i,
  output logic [N_PROC-1:0] flag_o,
  output logic [N_PROC-1:0] pend_o
);

  generate
    for (genvar g = 0; g < N_PROC; g++) begin : g_slot
      logic flag_q, pend_q;
      // a new mark in the clearing cycle wins
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          flag_q <= mark_i[g] | (flag_q & ~clear_i[g]);
          pend_q <= mark_i[g] | pixel_i[g] | (pend_q & ~clear_i[g]);
        end
      end
      assign flag_o[g] = flag_q;
      assign pend_o[g] = pend_q;
    end
  endgenerate

endmodule

// File: rtl/rps_seq.sv
module rps_seq
  import rps_pkg::*;
#(
  parameter int N_PROC    = 4,
  parameter int MULTI_MIN = 2,
  localparam int IDX_W    = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int STAT_W   = 3 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] flags_i,
  input  logic [N_PROC-1:0] pend_i,
  input  logic              wdog_i,
  input  logic              chk_done_i,
  input  logic              chk_fail_i,
  input  logic              reload_done_i,
  input  logic              sob_done_i,
  input  logic              sob_fail_i,
  output logic [N_PROC-1:0] clear_o,
  output logic [N_PROC-1:0] chk_start_o,
  output logic [N_PROC-1:0] proc_rst_o,
  output logic [N_PROC-1:0] reload_o,
  output logic              sob_rst_o,
  output logic              sob_start_o,
  output logic [STAT_W-1:0] status_o
);

  seq_state_e        st_q, st_d;
  fault_loc_e        loc_q, loc_d;
  logic [IDX_W-1:0]  idx_q, idx_d, fidx_q, fidx_d;
  logic              retry_q, retry_d, sh_ok_q, sh_ok_d, reprog_q, reprog_d;
  logic [N_PROC-1:0] sel;
  logic              many_flags;
  logic              chk_pass_ev, chk_fail_ev;

  assign sel         = N_PROC'(1) << idx_q;
  assign many_flags  = int'(flag_count(32'(flags_i))) >= MULTI_MIN;
  assign chk_pass_ev = (st_q == S_CHK_WAIT) && chk_done_i && !chk_fail_i;
  assign chk_fail_ev = (st_q == S_CHK_WAIT) && chk_done_i && chk_fail_i;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    retry_d  = retry_q;
    sh_ok_d  = sh_ok_q && many_flags;
    reprog_d = reprog_q;
    loc_d    = loc_q;
    fidx_d   = fidx_q;
    case (st_q)
      S_IDLE: begin
        if (many_flags && !sh_ok_q) begin
          st_d = S_SH_RST;
        end else if (pend_i != '0) begin
          idx_d   = IDX_W'(first_set(32'(pend_i)));
          retry_d = 1'b0;
          st_d    = S_CHK_GO;
        end
      end
      S_CHK_GO:  st_d = S_CHK_WAIT;
      S_CHK_WAIT: begin
        if (chk_pass_ev) begin
          st_d = S_IDLE;
        end else if (chk_fail_ev && !retry_q) begin
          st_d = S_PRST;
        end else if (chk_fail_ev) begin
          st_d     = S_HALT;
          reprog_d = 1'b1;
          loc_d    = LOC_PROC;
          fidx_d   = idx_q;
        end
      end
      S_PRST:    st_d = S_LOAD_GO;
      S_LOAD_GO: st_d = S_LOAD_WAIT;
      S_LOAD_WAIT: begin
        if (reload_done_i) begin
          retry_d = 1'b1;
          st_d    = S_CHK_GO;
        end
      end
      S_SH_RST: st_d = S_SH_GO;
      S_SH_GO:  st_d = S_SH_WAIT;
      S_SH_WAIT: begin
        if (sob_done_i && sob_fail_i) begin
          st_d     = S_HALT;
          reprog_d = 1'b1;
          loc_d    = LOC_SHARED;
        end else if (sob_done_i) begin
          sh_ok_d = 1'b1;
          st_d    = S_IDLE;
        end
      end
      S_HALT:  st_d = S_HALT;
      default: st_d = S_IDLE;
    endcase
    if (wdog_i && st_q != S_HALT) begin
      st_d     = S_HALT;
      reprog_d = 1'b1;
      loc_d    = LOC_CTRL;
      fidx_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      retry_q  <= 1'b0;
      sh_ok_q  <= 1'b0;
      reprog_q <= 1'b0;
      loc_q    <= LOC_NONE;
      fidx_q   <= '0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      retry_q  <= retry_d;
      sh_ok_q  <= sh_ok_d;
      reprog_q <= reprog_d;
      loc_q    <= loc_d;
      fidx_q   <= fidx_d;
    end
  end

  assign clear_o     = chk_pass_ev ? sel : '0;
  assign chk_start_o = (st_q == S_CHK_GO)  ? sel : '0;
  assign proc_rst_o  = (st_q == S_PRST)    ? sel : '0;
  assign reload_o    = (st_q == S_LOAD_GO) ? sel : '0;
  assign sob_rst_o   = (st_q == S_SH_RST);
  assign sob_start_o = (st_q == S_SH_GO);
  assign status_o    = {fidx_q, loc_q, reprog_q};

endmodule

// File: rtl/rps_recovery_seq.sv
module rps_recovery_seq #(
  parameter int N_PROC    = 4,
  parameter int MULTI_MIN = 2,
  localparam int IDX_W    = (N_PROC > 1) ? $clog2(N_PROC) : 1,
  localparam int STAT_W   = 3 + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] err_mark_i,
  input  logic [N_PROC-1:0] pixel_done_i,
  input  logic              wdog_i,
  input  logic              chk_done_i,
  input  logic              chk_fail_i,
  input  logic              reload_done_i,
  input  logic              sob_done_i,
  input  logic              sob_fail_i,
  output logic [N_PROC-1:0] err_flag_o,
  output logic [N_PROC-1:0] chk_start_o,
  output logic [N_PROC-1:0] proc_rst_o,
  output logic [N_PROC-1:0] reload_o,
  output logic              sob_rst_o,
  output logic              sob_start_o,
  output logic [STAT_W-1:0] status_o
);

  logic [N_PROC-1:0] pend_w;
  logic [N_PROC-1:0] clear_w;

  rps_flag_bank #(.N_PROC(N_PROC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .mark_i  (err_mark_i),
    .pixel_i (pixel_done_i),
    .clear_i (clear_w),
    .flag_o  (err_flag_o),
    .pend_o  (pend_w)
  );

  rps_seq #(.N_PROC(N_PROC), .MULTI_MIN(MULTI_MIN)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .flags_i       (err_flag_o),
    .pend_i        (pend_w),
    .wdog_i        (wdog_i),
    .chk_done_i    (chk_done_i),
    .chk_fail_i    (chk_fail_i),
    .reload_done_i (reload_done_i),
    .sob_done_i    (sob_done_i),
    .sob_fail_i    (sob_fail_i),
    .clear_o       (clear_w),
    .chk_start_o   (chk_start_o),
    .proc_rst_o    (proc_rst_o),
    .reload_o      (reload_o),
    .sob_rst_o     (sob_rst_o),
    .sob_start_o   (sob_start_o),
    .status_o      (status_o)
  );

endmodule

// File: rtl/rps_recovery_chk.sv
module rps_recovery_chk #(
  parameter int N_PROC = 4,
  parameter int STAT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PROC-1:0] err_mark_i,
  input logic [N_PROC-1:0] err_flag_o,
  input logic              wdog_i,
  input logic [N_PROC-1:0] chk_start_o,
  input logic [N_PROC-1:0] proc_rst_o,
  input logic [N_PROC-1:0] reload_o,
  input logic              sob_rst_o,
  input logic              sob_start_o,
  input logic [STAT_W-1:0] status_o
);

  a_r2_mark_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mark_i != '0) |=> ((err_flag_o & $past(err_mark_i)) == $past(err_mark_i)));

  a_r3_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chk_start_o));

  a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_start_o != '0) |=> (chk_start_o == '0));

  a_r4_reset_then_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_rst_o != '0) |=> (reload_o == $past(proc_rst_o)));

  a_r6_sob_reset_then_test: assert property (@(posedge clk) disable iff (!rst_n)
    sob_rst_o |=> sob_start_o);

  a_r8_watchdog_halts: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_i |=> (status_o[0] && status_o[2:1] != 2'd0));

  a_r9_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |=> $stable(status_o));

  a_r9_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> (chk_start_o == '0 && proc_rst_o == '0 && reload_o == '0
                     && !sob_rst_o && !sob_start_o));

endmodule

bind rps_recovery_seq rps_recovery_chk #(.N_PROC(N_PROC), .STAT_W(STAT_W)) u_rps_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_mark_i  (err_mark_i),
  .err_flag_o  (err_flag_o),
  .wdog_i      (wdog_i),
  .chk_start_o (chk_start_o),
  .proc_rst_o  (proc_rst_o),
  .reload_o    (reload_o),
  .sob_rst_o   (sob_rst_o),
  .sob_start_o (sob_start_o),
  .status_o    (status_o)
);

// File: tb/rps_recovery_seq_tb_top.sv
module rps_recovery_seq_tb_top;

  localparam int NP = 4;
  localparam int SW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NP-1:0] err_mark_i = '0, pixel_done_i = '0;
  logic          wdog_i = 1'b0;
  logic          chk_done_i = 1'b0, chk_fail_i = 1'b0, reload_done_i = 1'b0;
  logic          sob_done_i = 1'b0, sob_fail_i = 1'b0;
  logic [NP-1:0] err_flag_o, chk_start_o, proc_rst_o, reload_o;
  logic          sob_rst_o, sob_start_o;
  logic [SW-1:0] status_o;

  rps_recovery_seq #(.N_PROC(NP), .MULTI_MIN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .err_mark_i(err_mark_i), .pixel_done_i(pixel_done_i),
    .wdog_i(wdog_i), .chk_done_i(chk_done_i), .chk_fail_i(chk_fail_i),
    .reload_done_i(reload_done_i), .sob_done_i(sob_done_i), .sob_fail_i(sob_fail_i),
    .err_flag_o(err_flag_o), .chk_start_o(chk_start_o), .proc_rst_o(proc_rst_o),
    .reload_o(reload_o), .sob_rst_o(sob_rst_o), .sob_start_o(sob_start_o),
    .status_o(status_o)
  );

  int n_chk = 0, n_fail = 0;

  // responder bookkeeping: written only by the responder process
  int ev_start[NP] = '{default: 0};
  int ev_rst[NP]   = '{default: 0};
  int ev_load[NP]  = '{default: 0};
  int fail_used[NP] = '{default: 0};
  int ev_sobrst = 0, ev_sobgo = 0, ev_seq = 0, last_sob_seq = -1;
  int ord_idx[256], ord_seq[256];
  int ord_n = 0;
  int cur = 0;
  bit chk_w = 0, ld_w = 0, sh_w = 0;

  // plan: written only by the stimulus process
  int fail_lim[NP] = '{default: 0};
  bit sh_fail = 0;

  always @(negedge clk) begin
    chk_done_i = 1'b0; chk_fail_i = 1'b0; reload_done_i = 1'b0;
    sob_done_i = 1'b0; sob_fail_i = 1'b0;
    if (!rst_n) begin
      chk_w = 0; ld_w = 0; sh_w = 0;
    end else begin
      if (chk_w) begin
        chk_done_i = 1'b1;
        if (fail_used[cur] < fail_lim[cur]) begin
          chk_fail_i = 1'b1;
          fail_used[cur]++;
        end
        chk_w = 0;
      end
      if (ld_w) begin reload_done_i = 1'b1; ld_w = 0; end
      if (sh_w) begin sob_done_i = 1'b1; sob_fail_i = sh_fail; sh_w = 0; end
      for (int p = 0; p < NP; p++) begin
        if (chk_start_o[p]) begin
          ev_start[p]++; cur = p; chk_w = 1; ev_seq++;
          if (ord_n < 256) begin ord_idx[ord_n] = p; ord_seq[ord_n] = ev_seq; ord_n++; end
        end
        if (proc_rst_o[p]) ev_rst[p]++;
        if (reload_o[p]) begin ev_load[p]++; ld_w = 1; end
      end
      if (sob_rst_o) begin ev_sobrst++; ev_seq++; last_sob_seq = ev_seq; end
      if (sob_start_o) begin ev_sobgo++; sh_w = 1; end
    end
  end

  int b_start[NP], b_rst[NP], b_load[NP];
  int b_sobrst, b_sobgo, b_ord;

  task automatic snap();
    for (int p = 0; p < NP; p++) begin
      b_start[p] = ev_start[p]; b_rst[p] = ev_rst[p]; b_load[p] = ev_load[p];
      fail_lim[p] = fail_used[p];
    end
    b_sobrst = ev_sobrst; b_sobgo = ev_sobgo; b_ord = ord_n;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_status(bit rp, int loc, int idx);
    return int'(rp) + loc * 2 + idx * 8;
  endfunction

  task automatic pulse_in(logic [NP-1:0] mark, logic [NP-1:0] pix);
    err_mark_i = mark; pixel_done_i = pix;
    step(1);
    err_mark_i = '0; pixel_done_i = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic run_all();
    void'($urandom(32'd7321));
    do_reset();
    // R1 reset state
    check_eq("R1", "status", int'(status_o), 0);
    check_eq("R1", "flags", int'(err_flag_o), 0);
    check_eq("R1", "controls", int'({chk_start_o, proc_rst_o, reload_o, sob_rst_o, sob_start_o}), 0);

    // R3 pixel done queues one check, no flag
    snap();
    pulse_in('0, 4'b0100);
    step(12);
    check_eq("R3", "starts p2", ev_start[2] - b_start[2], 1);
    check_eq("R2", "flags after pixel", int'(err_flag_o), 0);

    // R2 mark sets flag, pass clears it
    snap();
    pulse_in(4'b0010, '0);
    check_eq("R2", "flag set", int'(err_flag_o[1]), 1);
    step(12);
    check_eq("R2", "flag cleared after pass", int'(err_flag_o[1]), 0);

    // R4 single failure: reset, reload, recheck; flag held meanwhile
    snap();
    fail_lim[3] = fail_used[3] + 1;
    pulse_in(4'b1000, '0);
    step(4);
    check_eq("R2", "flag held during recovery", int'(err_flag_o[3]), 1);
    step(30);
    check_eq("R4", "starts p3", ev_start[3] - b_start[3], 2);
    check_eq("R4", "resets p3", ev_rst[3] - b_rst[3], 1);
    check_eq("R4", "reloads p3", ev_load[3] - b_load[3], 1);
    check_eq("R4", "flag p3 cleared", int'(err_flag_o[3]), 0);
    check_eq("R4", "status ok", int'(status_o), 0);

    // R3 ordering: lowest index first
    snap();
    pulse_in('0, 4'b1111);
    step(40);
    for (int k = 0; k < NP; k++) check_eq("R3", "order", ord_idx[b_ord + k], k);
    check_eq("R6", "no shared test for pixels", ev_sobrst - b_sobrst, 0);

    // R6 two flags: shared test before checks
    snap();
    pulse_in(4'b0101, '0);
    step(40);
    check_eq("R6", "shared resets", ev_sobrst - b_sobrst, 1);
    check_eq("R6", "shared starts", ev_sobgo - b_sobgo, 1);
    check_eq("R6", "shared before check", int'(last_sob_seq < ord_seq[b_ord]), 1);
    check_eq("R6", "first check p0", ord_idx[b_ord], 0);
    check_eq("R6", "second check p2", ord_idx[b_ord + 1], 2);
    check_eq("R6", "flags cleared", int'(err_flag_o), 0);

    // R6 three flags: still one shared test
    snap();
    pulse_in(4'b0111, '0);
    step(40);
    check_eq("R6", "three flags shared once", ev_sobrst - b_sobrst, 1);
    check_eq("R6", "three flags status ok", int'(status_o), 0);

    // random rounds: pixel/mark mixes with single failures
    for (int r = 0; r < 30; r++) begin
      logic [NP-1:0] pix, mark, req;
      int f[NP];
      snap();
      pix  = NP'($urandom % 16);
      mark = ($urandom % 3 == 0) ? NP'(1 << ($urandom % NP)) : '0;
      req  = pix | mark;
      for (int p = 0; p < NP; p++) begin
        f[p] = req[p] ? int'($urandom % 2) : 0;
        fail_lim[p] = fail_used[p] + f[p];
      end
      pulse_in(mark, pix);
      step(60);
      for (int p = 0; p < NP; p++) begin
        check_eq("R3", "random starts", ev_start[p] - b_start[p], req[p] ? 1 + f[p] : 0);
        check_eq("R4", "random resets", ev_rst[p] - b_rst[p], f[p]);
      end
      check_eq("R6", "random no shared", ev_sobrst - b_sobrst, 0);
      check_eq("R2", "random flags clear", int'(err_flag_o), 0);
      check_eq("R9", "random status ok", int'(status_o), 0);
    end

    // R5 double failure on p2
    do_reset();
    snap();
    fail_lim[2] = fail_used[2] + 2;
    pulse_in(4'b0100, '0);
    step(40);
    check_eq("R5", "status proc fault", int'(status_o), exp_status(1, 3, 2));
    check_eq("R10", "failing index field", int'(status_o[4:3]), 2);
    check_eq("R2", "flag kept after failed recovery", int'(err_flag_o[2]), 1);
    snap();
    pulse_in('0, 4'b0001);
    step(15);
    check_eq("R9", "no check while halted", ev_start[0] - b_start[0], 0);
    check_eq("R9", "status frozen", int'(status_o), exp_status(1, 3, 2));

    // R7 shared test failure
    do_reset();
    snap();
    sh_fail = 1;
    pulse_in(4'b0011, '0);
    step(20);
    sh_fail = 0;
    check_eq("R7", "status shared fault", int'(status_o), exp_status(1, 2, 0));
    check_eq("R9", "no checks after shared fail", (ev_start[0] - b_start[0]) + (ev_start[1] - b_start[1]), 0);

    // R8 watchdog in idle
    do_reset();
    wdog_i = 1'b1;
    step(1);
    wdog_i = 1'b0;
    check_eq("R8", "watchdog idle", int'(status_o), exp_status(1, 1, 0));
    step(10);
    check_eq("R9", "watchdog sticky", int'(status_o), exp_status(1, 1, 0));

    // R8 watchdog mid-recovery
    do_reset();
    snap();
    fail_lim[3] = fail_used[3] + 1;
    pulse_in('0, 4'b1000);
    step(5);
    wdog_i = 1'b1;
    step(1);
    wdog_i = 1'b0;
    step(20);
    check_eq("R8", "watchdog mid-recovery", int'(status_o), exp_status(1, 1, 0));
    check_eq("R9", "no recheck after watchdog", ev_start[3] - b_start[3], 1);

    // R1 reset clears sticky state
    do_reset();
    check_eq("R1", "status after re-reset", int'(status_o), 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 0;
    fork
      run_all();
      begin
        #(20 * 150000);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule